// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Upper-Quarter Write Guard

This block is a two-wire (I2C) bus slave that sits in front of an 8192-byte on-chip byte array. A faster system clock samples the bus clock and data lines through synchronizers. On those sampled lines the block finds start and stop conditions, decodes the device-select byte, and runs byte writes, page writes, current-address reads, random reads and sequential reads. It never drives the data line high. It either pulls it low or lets the external pull-up hold it.

Three strap inputs give the device its bus identity, so up to eight copies can share one bus. A write-guard input protects the top quarter of the array (1800h to 1FFFh) from writes. Reads of that region always return the stored data. Write data is gathered in a 32-byte page buffer and copied into the array only after the stop condition.

Top module: `i2c_eeprom_wp`

## Requirements
- R1: After reset the data-line drive output `sda_oe` is 0, and it stays 0 whenever the block is idle.
- R2: A device-select byte is acknowledged (data held low for the ninth clock) only when its bits 7:4 equal 1010 and its bits 3:1 equal `strap_i`. Bit 0 set to 1 means read. Any other byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: After a write select, the block takes a high address byte and then a low address byte and acknowledges both. Bits 4:0 of the high byte and all 8 bits of the low byte form the 13-bit address. Bits 7:5 of the high byte are ignored.
- R4: A data byte that follows the address is acknowledged and stored at that address. It can be read back after the stop condition.
- R5: Consecutive data bytes fill a 32-byte page. Only address bits 4:0 advance, wrapping within the page, and the page is committed to the array at the stop condition.
- R6: While `wp_i` is 1, data bytes aimed at 1800h–1FFFh are acknowledged but discarded. Addresses below 1800h stay writable. While `wp_i` is 0, every address can be written.
- R7: Reads return the stored byte whatever the level of `wp_i`, including reads inside 1800h–1FFFh.
- R8: A write select with two address bytes, then a repeated start and a read select, returns the byte at that address, most significant bit first.
- R9: During a read, a master acknowledge makes the block send the next byte. The address advances by one after each byte and wraps from 1FFFh to 0000h. A master no-acknowledge ends the read, and the data line is released.
- R10: A read select with no address phase returns the byte at the address just after the last byte read.
- R11: A falling data line while the clock is high starts a transaction, and a rising data line while the clock is high ends one. The block changes `sda_oe` from 0 to 1 only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| strap_i | input | 3 | Device identity straps compared with select bits 3:1 |
| wp_i | input | 1 | Write guard for the top quarter of the array |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Single-byte writes followed by random reads are driven at the two sides of the 1800h boundary and at the last address, with the write guard both on and off. These separate a guard that covers the wrong range or also blocks reads from a correct one. A page write that starts two bytes before the end of a page shows whether the address wraps inside the page or carries into the next one. A sequential read across 1FFFh shows the full-array wrap. A current-address read placed after a random read shows whether the pointer is kept between transactions. Select bytes with the wrong straps and with the wrong control code must get no acknowledge. A high address byte with its unused bits set must not change the address used.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADRH,
    ST_ADRL,
    ST_WDAT,
    ST_RD,
    ST_COMMIT
  } eep_st_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_N-1];
      sda_q  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic          keep,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          any_valid
);
  localparam int N = 1 << PW;
  logic [DW-1:0] dat [N];
  logic [N-1:0]  vld;

  always_ff @(posedge clk) begin
    if (we) dat[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[waddr] <= keep;
  end

  assign rdata     = dat[raddr];
  assign rvalid    = vld[raddr];
  assign any_valid = |vld;
endmodule

// File: rtl/i2c_eeprom_wp.sv
module i2c_eeprom_wp #(
  parameter int         AW     = 13,
  parameter int         PW     = 5,
  parameter int         SYNC_N = 2,
  parameter logic [3:0] CTRL   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  import eep_pkg::*;

  localparam int HI_BITS = AW - 8;

  eep_st_e       state;
  logic [AW-1:0] ptr;
  logic [7:0]    sh, tx;
  logic [3:0]    cnt;
  logic          ack_ph, mack, nack, rd_sel;
  logic [PW-1:0] cidx;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, pb_rdata;
  logic pb_rvalid, pb_any, pb_we, pb_keep, pb_clr, mem_we;
  logic rx_state, prot;

  eep_bus_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rx_state = (state == ST_DEV) || (state == ST_ADRH) ||
                    (state == ST_ADRL) || (state == ST_WDAT);
  assign prot     = wp_i && (ptr[AW-1 -: 2] == 2'b11);
  assign pb_we    = (state == ST_WDAT) && scl_fall && !ack_ph && (cnt == 4'd8)
                    && !start_det && !stop_det;
  assign pb_keep  = !prot;
  assign pb_clr   = (start_det && state != ST_COMMIT) ||
                    (state == ST_COMMIT && cidx == '1);
  assign mem_we   = (state == ST_COMMIT) && pb_rvalid;

  eep_page_buf #(.PW(PW), .DW(8)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .we(pb_we), .keep(pb_keep),
    .waddr(ptr[PW-1:0]), .wdata(sh), .raddr(cidx),
    .rdata(pb_rdata), .rvalid(pb_rvalid), .any_valid(pb_any)
  );

  eep_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr({ptr[AW-1:PW], cidx}), .wdata(pb_rdata),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      sh     <= '0;
      tx     <= '0;
      cnt    <= '0;
      ack_ph <= 1'b0;
      mack   <= 1'b0;
      nack   <= 1'b0;
      rd_sel <= 1'b0;
      cidx   <= '0;
      sda_oe <= 1'b0;
    end else if (state == ST_COMMIT) begin
      cidx <= cidx + 1'b1;
      if (cidx == '1) state <= ST_IDLE;
    end else if (start_det) begin
      state  <= ST_DEV;
      cnt    <= '0;
      ack_ph <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      sda_oe <= 1'b0;
      ack_ph <= 1'b0;
      cidx   <= '0;
      state  <= pb_any ? ST_COMMIT : ST_IDLE;
    end else if (rx_state) begin
      if (scl_rise && !ack_ph && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end else if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        cnt    <= '0;
        sda_oe <= 1'b0;
        case (state)
          ST_DEV: begin
            if (rd_sel) begin
              state  <= ST_RD;
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              mack   <= 1'b0;
              nack   <= 1'b0;
            end else begin
              state <= ST_ADRH;
            end
          end
          ST_ADRH: state <= ST_ADRL;
          ST_ADRL: state <= ST_WDAT;
          default: state <= ST_WDAT;
        endcase
      end else if (scl_fall && cnt == 4'd8) begin
        case (state)
          ST_DEV: begin
            if (sh[7:4] == CTRL && sh[3:1] == strap_i) begin
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
              rd_sel <= sh[0];
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADRH: begin
            ptr[AW-1:8] <= sh[HI_BITS-1:0];
            sda_oe <= 1'b1;
            ack_ph <= 1'b1;
          end
          ST_ADRL: begin
            ptr[7:0] <= sh;
            sda_oe <= 1'b1;
            ack_ph <= 1'b1;
          end
          default: begin
            ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
            sda_oe <= 1'b1;
            ack_ph <= 1'b1;
          end
        endcase
      end
    end else if (state == ST_RD) begin
      if (scl_rise) begin
        if (!mack) cnt <= cnt + 1'b1;
        else       nack <= sda_s;
      end else if (scl_fall) begin
        if (!mack) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            mack   <= 1'b1;
            ptr    <= ptr + 1'b1;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end else if (nack) begin
          state <= ST_IDLE;
          mack  <= 1'b0;
        end else begin
          tx     <= rd_data;
          sda_oe <= ~rd_data[7];
          cnt    <= '0;
          mack   <= 1'b0;
        end
      end
    end
  end

  // R1: bus released while idle
  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R11: the drive is only switched on while the sampled clock is low
  p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R11: a start outside a commit always opens a device-select phase
  p_start_enters_select_r11: assert property (@(posedge clk) disable iff (rst)
    (start_det && state != ST_COMMIT) |=> (state == ST_DEV));

  // R5: the array is only written after a stop condition
  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMMIT && $past(state) != ST_COMMIT) |-> $past(stop_det));

  // R9: line released while the master acknowledges a read byte
  p_rd_released_mack_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && mack) |-> !sda_oe);
endmodule

// File: tb/i2c_eeprom_wp_test.sv
module i2c_eeprom_wp_test;
  localparam time H = 200ns;
  localparam time Q = 100ns;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NV = 7;
  // {addr[12:0], data[7:0], wp, expected[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {13'h1800, 8'h11, 1'b0, 8'h11},
    {13'h1800, 8'h77, 1'b1, 8'h11},
    {13'h17FF, 8'h33, 1'b1, 8'h33},
    {13'h1FFF, 8'hC3, 1'b0, 8'hC3},
    {13'h1FFF, 8'h00, 1'b1, 8'hC3},
    {13'h0000, 8'h5A, 1'b1, 8'h5A},
    {13'h0ABC, 8'h9E, 1'b0, 8'h9E}
  };

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = ~(m_low | sda_oe);
  int   n_chk = 0, n_fail = 0, viol = 0;
  bit   done = 1'b0;

  always #5ns clk = ~clk;

  i2c_eeprom_wp uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(STRAP), .wp_i(wp), .sda_oe(sda_oe)
  );

  // R11 monitor: drive may only change while the bus clock is low
  always @(sda_oe) if (!rst && scl) viol++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; #Q; scl = 1'b1; #H; scl = 1'b0; #Q;
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; #Q; scl = 1'b1; #(H/2); b = sda_bus; #(H/2); scl = 1'b0; #Q;
  endtask

  task automatic i2c_start();
    m_low = 1'b0; #Q; scl = 1'b1; #H; m_low = 1'b1; #H; scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; #Q; scl = 1'b1; #H; m_low = 1'b0; #H; #1us;
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(ack);
  endtask

  task automatic recv(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic set_addr(input logic [12:0] a, input logic [2:0] junk, output logic nak);
    logic k0, k1, k2;
    i2c_start();
    send({4'b1010, STRAP, 1'b0}, k0);
    send({junk, a[12:8]}, k1);
    send(a[7:0], k2);
    nak = k0 | k1 | k2;
  endtask

  task automatic rd_sel(output logic nak);
    i2c_start();
    send({4'b1010, STRAP, 1'b1}, nak);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic nak, k;
    logic [7:0] d, d2;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset release", {7'd0, sda_oe}, 8'h00);

    // wrong straps, then wrong control code
    i2c_start(); send({4'b1010, 3'b010, 1'b0}, k); i2c_stop();
    chk("R2 strap mismatch nack", {7'd0, k}, 8'h01);
    i2c_start(); send({4'b1011, STRAP, 1'b0}, k); i2c_stop();
    chk("R2 control code mismatch nack", {7'd0, k}, 8'h01);
    chk("R1 idle after bad select", {7'd0, sda_oe}, 8'h00);

    // table walk: byte write then random read, each with its own guard level
    for (int v = 0; v < NV; v++) begin
      wp = VEC[v][8];
      set_addr(VEC[v][29:17], 3'b101, nak);
      send(VEC[v][16:9], k);
      i2c_stop();
      chk("R3 R2 write header acks", {7'd0, nak}, 8'h00);
      chk("R6 data byte acked", {7'd0, k}, 8'h00);
      set_addr(VEC[v][29:17], 3'b000, nak);
      rd_sel(k);
      recv(1'b1, d);
      i2c_stop();
      chk("R8 random read acks", {7'd0, nak | k}, 8'h00);
      chk("R4 R6 R7 readback", d, VEC[v][7:0]);
    end

    // page write wrapping inside the page: 5E,5F,40,41
    wp = 1'b0;
    set_addr(13'h005E, 3'b000, nak);
    send(8'hA1, k); send(8'hA2, k); send(8'hA3, k); send(8'hA4, k);
    i2c_stop();
    set_addr(13'h0040, 3'b000, nak); rd_sel(k);
    recv(1'b0, d); recv(1'b1, d2); i2c_stop();
    chk("R5 page wrap byte 40", d, 8'hA3);
    chk("R5 page wrap byte 41", d2, 8'hA4);
    set_addr(13'h005E, 3'b000, nak); rd_sel(k);
    recv(1'b0, d); recv(1'b1, d2); i2c_stop();
    chk("R9 sequential 5E", d, 8'hA1);
    chk("R9 sequential 5F", d2, 8'hA2);

    // current-address read after a one-byte random read of 5E
    set_addr(13'h005E, 3'b000, nak); rd_sel(k); recv(1'b1, d); i2c_stop();
    rd_sel(k); recv(1'b1, d2); i2c_stop();
    chk("R10 current address read", d2, 8'hA2);

    // sequential read across the top of the array
    wp = 1'b1;
    set_addr(13'h1FFF, 3'b000, nak); rd_sel(k);
    recv(1'b0, d); recv(1'b1, d2);
    chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    i2c_stop();
    chk("R9 R7 read 1FFF", d, 8'hC3);
    chk("R9 wrap to 0000", d2, 8'h5A);

    // protected page write: acked but discarded
    set_addr(13'h1FFE, 3'b000, nak);
    send(8'h01, k); send(8'h02, d[0]);
    i2c_stop();
    chk("R6 protected page acks", {6'd0, k, d[0]}, 8'h00);
    set_addr(13'h1FFF, 3'b000, nak); rd_sel(k); recv(1'b1, d); i2c_stop();
    chk("R6 protected byte unchanged", d, 8'hC3);

    chk("R11 drive changes only with clock low", viol[7:0], 8'h00);
    chk("R1 idle at end", {7'd0, sda_oe}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule